// File: doc/BRIEF.md
# Masked Cross-Lane Permute Unit

This block moves data between the lanes of a 64-lane vector register in one clocked step. Lanes are grouped into four rows of sixteen, and each row into four banks of four lanes. A source vector is rearranged in one of four ways: a plain copy, a right shift inside each row, a broadcast of the last lane of one row into the next row, or a broadcast of lane 31 into the upper two rows. The rearranged value, optionally combined per lane with a second operand, is then merged into the old destination vector.

Three masks decide which lanes may change: a per-row mask, a per-bank mask (the same bank pattern applies inside every row) and a per-lane active mask. A lane whose rearranged read points outside the legal range follows a fill rule. It either receives zero or keeps its old destination value. A compiler can therefore build prefix scans for operators whose identity is not zero by tying source and destination. The new destination vector is registered and appears one clock after the inputs.

Top module: `lane_permute_unit`

## Requirements
- R1: While the active-low reset is asserted, and in the first cycle after it, the destination output is all zeros.
- R2: In shift mode (mode code 1) with amount n from 1 to 15, lane k of a row receives source lane k-n of the same row when k >= n. Data never crosses a row boundary.
- R3: A written lane whose read is out of range (k < n in shift mode, row 0 for the row-15 broadcast, rows 0 and 1 for the lane-31 broadcast) receives zero when the fill control is 0.
- R4: With the fill control at 1, the same out-of-range lanes keep their old destination value.
- R5: In row broadcast mode (mode code 2), every lane of row r (r >= 1) receives source lane 16*r-1.
- R6: In high broadcast mode (mode code 3), every lane of rows 2 and 3 receives source lane 31.
- R7: Row mask bit r gates lanes 16*r to 16*r+15. A lane whose row bit is 0 keeps its old destination value.
- R8: Bank mask bit b gates every lane whose position inside its row, divided by 4, equals b. A lane whose bank bit is 0 keeps its old value.
- R9: A lane whose active mask bit is 0 keeps its old destination value.
- R10: Copy mode (mode code 0), and shift mode with amount 0, write source lane i into lane i.
- R11: With the combine enable set, a written in-range lane receives op(permuted source, operand lane). The op codes are 0 add modulo 2^DW, 1 unsigned minimum, 2 unsigned maximum and 3 exclusive or. Out-of-range lanes skip the operator and follow R3/R4.
- R12: The result for inputs presented before a rising clock edge appears on the output after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_vec_i | input | LANES*DW | Source vector, lane i at bits i*DW |
| old_vec_i | input | LANES*DW | Old destination vector |
| opnd_vec_i | input | LANES*DW | Second operand for combine |
| mode_i | input | 2 | 0 copy, 1 row shift right, 2 row-15 broadcast, 3 lane-31 broadcast |
| shamt_i | input | 4 | Shift amount |
| row_mask_i | input | 4 | Row write mask |
| bank_mask_i | input | 4 | Bank write mask |
| bound_keep_i | input | 1 | Out-of-range fill: 0 zero, 1 keep old |
| fuse_en_i | input | 1 | Combine enable |
| fuse_op_i | input | 2 | Combine operator code |
| active_i | input | LANES | Per-lane active mask |
| dst_vec_o | output | LANES*DW | New destination vector, registered |

## Verification
The assertions assume that every control and data input is stable and known at each rising edge, and that the mask and mode inputs seen at one edge belong to the result checked at the next. The lane-31 broadcast assertion also assumes that the combine enable is low. The bench changes inputs only on falling edges and never leaves an input undriven, so each sampled edge sees one complete, defined control word. Random controls cover every mode and operator, including shift amounts of 0 and 15 and empty or full masks.

// File: rtl/lpu_pkg.sv
package lpu_pkg;
   localparam int LPU_ROWS  = 4;
   localparam int LPU_BANKS = 4;

   typedef enum logic [1:0] {
      MODE_COPY = 2'd0,
      MODE_SHR  = 2'd1,
      MODE_B15  = 2'd2,
      MODE_B31  = 2'd3
   } lpu_mode_e;

   typedef enum logic [1:0] {
      FOP_ADD = 2'd0,
      FOP_MIN = 2'd1,
      FOP_MAX = 2'd2,
      FOP_XOR = 2'd3
   } lpu_fop_e;
endpackage

// File: rtl/lpu_route.sv
module lpu_route
   import lpu_pkg::*;
#(
   parameter int LANES     = 64,
   parameter int DW        = 32,
   parameter int ROW_LANES = LANES / LPU_ROWS,
   parameter int SH_W      = $clog2(ROW_LANES),
   parameter int LANE_W    = $clog2(LANES)
) (
   input  logic [LANES*DW-1:0] src_vec_i,
   input  lpu_mode_e           mode_i,
   input  logic [SH_W-1:0]     shamt_i,
   output logic [LANES*DW-1:0] perm_vec_o,
   output logic [LANES-1:0]    perm_ok_o
);
   logic [DW-1:0] src_a [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_unpack
      assign src_a[g] = src_vec_i[g*DW +: DW];
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int              ROW    = g / ROW_LANES;
      localparam int              POS    = g % ROW_LANES;
      localparam logic [SH_W-1:0] POS_V  = SH_W'(POS);
      localparam bit              B15_OK = (ROW != 0);
      localparam int              B15_SRC = B15_OK ? (ROW * ROW_LANES - 1) : 0;
      localparam bit              B31_OK = (ROW >= 2);
      localparam int              B31_SRC = 2 * ROW_LANES - 1;

      logic [LANE_W-1:0] idx_l;
      logic              ok_l;

      always_comb begin
         ok_l  = 1'b1;
         idx_l = LANE_W'(g);
         unique case (mode_i)
            MODE_COPY: idx_l = LANE_W'(g);
            MODE_SHR: begin
               if (shamt_i != '0) begin
                  if (POS_V >= shamt_i) begin
                     idx_l = LANE_W'(g) - {{(LANE_W-SH_W){1'b0}}, shamt_i};
                  end else begin
                     ok_l = 1'b0;
                  end
               end
            end
            MODE_B15: begin
               ok_l  = B15_OK;
               idx_l = LANE_W'(B15_SRC);
            end
            MODE_B31: begin
               ok_l  = B31_OK;
               idx_l = LANE_W'(B31_SRC);
            end
            default: ok_l = 1'b0;
         endcase
      end

      assign perm_vec_o[g*DW +: DW] = src_a[idx_l];
      assign perm_ok_o[g]           = ok_l;
   end
endmodule

// File: rtl/lpu_fuse.sv
module lpu_fuse
   import lpu_pkg::*;
#(
   parameter int LANES   = 64,
   parameter int DW      = 32,
   parameter bit FUSE_EN = 1'b1
) (
   input  logic [LANES*DW-1:0] perm_vec_i,
   input  logic [LANES*DW-1:0] opnd_vec_i,
   input  logic                fuse_en_i,
   input  lpu_fop_e            fuse_op_i,
   output logic [LANES*DW-1:0] fused_vec_o
);
   if (FUSE_EN) begin : g_alu
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [DW-1:0] a_l, b_l, r_l;
         assign a_l = perm_vec_i[g*DW +: DW];
         assign b_l = opnd_vec_i[g*DW +: DW];

         always_comb begin
            r_l = a_l;
            if (fuse_en_i) begin
               unique case (fuse_op_i)
                  FOP_ADD: r_l = a_l + b_l;
                  FOP_MIN: r_l = (a_l < b_l) ? a_l : b_l;
                  FOP_MAX: r_l = (a_l > b_l) ? a_l : b_l;
                  FOP_XOR: r_l = a_l ^ b_l;
                  default: r_l = a_l;
               endcase
            end
         end

         assign fused_vec_o[g*DW +: DW] = r_l;
      end
   end else begin : g_bypass
      assign fused_vec_o = perm_vec_i;
   end
endmodule

// File: rtl/lpu_merge.sv
module lpu_merge
   import lpu_pkg::*;
#(
   parameter int LANES      = 64,
   parameter int DW         = 32,
   parameter int ROW_LANES  = LANES / LPU_ROWS,
   parameter int BANK_LANES = ROW_LANES / LPU_BANKS
) (
   input  logic [LANES*DW-1:0]  fused_vec_i,
   input  logic [LANES-1:0]     perm_ok_i,
   input  logic [LANES*DW-1:0]  old_vec_i,
   input  logic [LANES-1:0]     active_i,
   input  logic [LPU_ROWS-1:0]  row_mask_i,
   input  logic [LPU_BANKS-1:0] bank_mask_i,
   input  logic                 bound_keep_i,
   output logic [LANES*DW-1:0]  next_vec_o
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int ROW  = g / ROW_LANES;
      localparam int BANK = (g % ROW_LANES) / BANK_LANES;

      logic          we_l;
      logic [DW-1:0] old_l, nxt_l;

      assign we_l  = active_i[g] & row_mask_i[ROW] & bank_mask_i[BANK];
      assign old_l = old_vec_i[g*DW +: DW];

      always_comb begin
         if (!we_l) begin
            nxt_l = old_l;
         end else if (perm_ok_i[g]) begin
            nxt_l = fused_vec_i[g*DW +: DW];
         end else if (bound_keep_i) begin
            nxt_l = old_l;
         end else begin
            nxt_l = '0;
         end
      end

      assign next_vec_o[g*DW +: DW] = nxt_l;
   end
endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
   import lpu_pkg::*;
#(
   parameter int LANES      = 64,
   parameter int DW         = 32,
   parameter int BANK_LANES = 4,
   parameter bit FUSE_EN    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LANES*DW-1:0]  src_vec_i,
   input  logic [LANES*DW-1:0]  old_vec_i,
   input  logic [LANES*DW-1:0]  opnd_vec_i,
   input  logic [1:0]           mode_i,
   input  logic [3:0]           shamt_i,
   input  logic [3:0]           row_mask_i,
   input  logic [3:0]           bank_mask_i,
   input  logic                 bound_keep_i,
   input  logic                 fuse_en_i,
   input  logic [1:0]           fuse_op_i,
   input  logic [LANES-1:0]     active_i,
   output logic [LANES*DW-1:0]  dst_vec_o
);
   localparam int ROW_LANES = LANES / LPU_ROWS;
   localparam int SH_W      = $clog2(ROW_LANES);
   localparam int LANE_W    = $clog2(LANES);

   if (LANES != 64) begin : g_chk_lanes
      $error("lane_permute_unit: LANES must be 64");
   end
   if (ROW_LANES != LPU_BANKS * BANK_LANES) begin : g_chk_bank
      $error("lane_permute_unit: row must hold four banks");
   end
   if (DW < 1) begin : g_chk_dw
      $error("lane_permute_unit: DW must be positive");
   end
   if (SH_W != 4) begin : g_chk_sh
      $error("lane_permute_unit: shift field must be 4 bits");
   end

   logic [LANES*DW-1:0] perm_vec, fused_vec, next_vec, dst_q;
   logic [LANES-1:0]    perm_ok;
   logic                primed_q;

   lpu_route #(
      .LANES(LANES), .DW(DW), .ROW_LANES(ROW_LANES), .SH_W(SH_W), .LANE_W(LANE_W)
   ) route_i (
      .src_vec_i (src_vec_i),
      .mode_i    (lpu_mode_e'(mode_i)),
      .shamt_i   (shamt_i),
      .perm_vec_o(perm_vec),
      .perm_ok_o (perm_ok)
   );

   lpu_fuse #(
      .LANES(LANES), .DW(DW), .FUSE_EN(FUSE_EN)
   ) fuse_i (
      .perm_vec_i (perm_vec),
      .opnd_vec_i (opnd_vec_i),
      .fuse_en_i  (fuse_en_i),
      .fuse_op_i  (lpu_fop_e'(fuse_op_i)),
      .fused_vec_o(fused_vec)
   );

   lpu_merge #(
      .LANES(LANES), .DW(DW), .ROW_LANES(ROW_LANES), .BANK_LANES(BANK_LANES)
   ) merge_i (
      .fused_vec_i (fused_vec),
      .perm_ok_i   (perm_ok),
      .old_vec_i   (old_vec_i),
      .active_i    (active_i),
      .row_mask_i  (row_mask_i),
      .bank_mask_i (bank_mask_i),
      .bound_keep_i(bound_keep_i),
      .next_vec_o  (next_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dst_q    <= '0;
         primed_q <= 1'b0;
      end else begin
         dst_q    <= next_vec;
         primed_q <= 1'b1;
      end
   end

   assign dst_vec_o = dst_q;

   for (genvar g = 0; g < LANES; g++) begin : g_chk
      localparam int ROW  = g / ROW_LANES;
      localparam int POS  = g % ROW_LANES;
      localparam int BANK = POS / BANK_LANES;

      // R9: inactive lane keeps old value
      a_r9_inactive_keep: assert property (@(posedge clk) disable iff (!rst_n)
         (primed_q && $past(!active_i[g])) |->
         dst_q[g*DW +: DW] == $past(old_vec_i[g*DW +: DW]));

      // R7: masked row keeps old value
      a_r7_row_keep: assert property (@(posedge clk) disable iff (!rst_n)
         (primed_q && $past(!row_mask_i[ROW])) |->
         dst_q[g*DW +: DW] == $past(old_vec_i[g*DW +: DW]));

      // R3: out-of-range shift read fills zero
      a_r3_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
         (primed_q && $past(mode_i == 2'd1 && shamt_i > SH_W'(POS) && active_i[g]
            && row_mask_i[ROW] && bank_mask_i[BANK] && !bound_keep_i)) |->
         dst_q[g*DW +: DW] == '0);

      if (ROW >= 2) begin : g_b31
         // R6: upper rows take lane 31
         a_r6_bcast_hi: assert property (@(posedge clk) disable iff (!rst_n)
            (primed_q && $past(mode_i == 2'd3 && !fuse_en_i && active_i[g]
               && row_mask_i[ROW] && bank_mask_i[BANK])) |->
            dst_q[g*DW +: DW] == $past(src_vec_i[31*DW +: DW]));
      end
   end
endmodule

// File: tb/lane_permute_unit_tb_top.sv
`timescale 1ns/1ps
module lane_permute_unit_tb_top;
   localparam int LANES = 64;
   localparam int DW    = 32;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [LANES*DW-1:0] src_vec, old_vec, opnd_vec, dst_vec;
   logic [1:0]          mode = '0;
   logic [3:0]          shamt = '0;
   logic [3:0]          row_mask = '0;
   logic [3:0]          bank_mask = '0;
   logic                bound_keep = 1'b0;
   logic                fuse_en = 1'b0;
   logic [1:0]          fuse_op = '0;
   logic [LANES-1:0]    active = '0;

   logic [DW-1:0] src_m [LANES];
   logic [DW-1:0] old_m [LANES];
   logic [DW-1:0] opd_m [LANES];
   logic [DW-1:0] exp_m [LANES];

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lane_permute_unit dut_i (
      .clk(clk), .rst_n(rst_n),
      .src_vec_i(src_vec), .old_vec_i(old_vec), .opnd_vec_i(opnd_vec),
      .mode_i(mode), .shamt_i(shamt), .row_mask_i(row_mask),
      .bank_mask_i(bank_mask), .bound_keep_i(bound_keep),
      .fuse_en_i(fuse_en), .fuse_op_i(fuse_op), .active_i(active),
      .dst_vec_o(dst_vec)
   );

   function automatic logic [DW-1:0] model(int i);
      int r, k, b, s, sh;
      bit ok;
      logic [DW-1:0] v, o;
      r = i / 16; k = i % 16; b = k / 4; sh = int'(shamt);
      ok = 1'b1; s = i;
      if (!active[i] || !row_mask[r] || !bank_mask[b]) return old_m[i];
      case (mode)
         2'd1: if (sh != 0) begin
                  if (k >= sh) s = i - sh; else ok = 1'b0;
               end
         2'd2: if (r >= 1) s = 16 * r - 1; else ok = 1'b0;
         2'd3: if (r >= 2) s = 31; else ok = 1'b0;
         default: s = i;
      endcase
      if (!ok) return bound_keep ? old_m[i] : '0;
      v = src_m[s];
      if (!fuse_en) return v;
      o = opd_m[i];
      case (fuse_op)
         2'd0: return v + o;
         2'd1: return (v < o) ? v : o;
         2'd2: return (v > o) ? v : o;
         default: return v ^ o;
      endcase
   endfunction

   task automatic pack_inputs();
      for (int i = 0; i < LANES; i++) begin
         src_vec[i*DW +: DW]  = src_m[i];
         old_vec[i*DW +: DW]  = old_m[i];
         opnd_vec[i*DW +: DW] = opd_m[i];
      end
   endtask

   task automatic fill_random();
      for (int i = 0; i < LANES; i++) begin
         src_m[i] = $urandom;
         old_m[i] = $urandom;
         opd_m[i] = $urandom;
      end
   endtask

   task automatic set_ctl(input logic [1:0] md, input logic [3:0] sh,
                          input logic [3:0] rm, input logic [3:0] bm,
                          input logic bk, input logic fe, input logic [1:0] fo,
                          input logic [LANES-1:0] act);
      mode = md; shamt = sh; row_mask = rm; bank_mask = bm;
      bound_keep = bk; fuse_en = fe; fuse_op = fo; active = act;
   endtask

   task automatic compare(input string tag);
      int bad;
      bad = -1;
      for (int i = 0; i < LANES; i++)
         if (bad < 0 && dst_vec[i*DW +: DW] !== exp_m[i]) bad = i;
      checks++;
      if (bad >= 0) begin
         failures++;
         $display("FAIL %s lane %0d actual=%h expected=%h", tag, bad,
                  dst_vec[bad*DW +: DW], exp_m[bad]);
      end
   endtask

   // drive on falling edge, result registered at next rising edge, check at following falling edge
   task automatic run(input string tag);
      @(negedge clk);
      pack_inputs();
      for (int i = 0; i < LANES; i++) exp_m[i] = model(i);
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] prev [LANES];
      fill_random();
      pack_inputs();
      set_ctl(2'd1, 4'd3, 4'hf, 4'hf, 1'b0, 1'b0, 2'd0, '1);
      repeat (3) @(negedge clk);
      // R1: reset holds zero
      for (int i = 0; i < LANES; i++) exp_m[i] = '0;
      compare("R1 reset");
      rst_n = 1'b1;
      for (int i = 0; i < LANES; i++) exp_m[i] = '0;
      compare("R1 after release");

      fill_random();
      set_ctl(2'd1, 4'd3, 4'hf, 4'hf, 1'b0, 1'b0, 2'd0, '1);
      run("R2 R3 shift3 zero fill");
      fill_random();
      set_ctl(2'd1, 4'd15, 4'hf, 4'hf, 1'b0, 1'b0, 2'd0, '1);
      run("R2 R3 shift15");
      fill_random();
      set_ctl(2'd1, 4'd5, 4'hf, 4'hf, 1'b1, 1'b0, 2'd0, '1);
      run("R4 shift5 keep old");
      fill_random();
      set_ctl(2'd2, 4'd0, 4'hf, 4'hf, 1'b0, 1'b0, 2'd0, '1);
      run("R5 row broadcast");
      fill_random();
      set_ctl(2'd3, 4'd0, 4'hf, 4'hf, 1'b1, 1'b0, 2'd0, '1);
      run("R6 lane31 broadcast");
      fill_random();
      set_ctl(2'd0, 4'd0, 4'b0101, 4'hf, 1'b0, 1'b0, 2'd0, '1);
      run("R7 row mask");
      fill_random();
      set_ctl(2'd1, 4'd1, 4'hf, 4'b1010, 1'b0, 1'b0, 2'd0, '1);
      run("R8 bank mask");
      fill_random();
      set_ctl(2'd2, 4'd0, 4'hf, 4'hf, 1'b0, 1'b0, 2'd0, 64'h0f0f_3c3c_a5a5_1248);
      run("R9 active mask");
      fill_random();
      set_ctl(2'd0, 4'd7, 4'hf, 4'hf, 1'b0, 1'b0, 2'd0, '1);
      run("R10 copy mode");
      fill_random();
      set_ctl(2'd1, 4'd0, 4'hf, 4'hf, 1'b0, 1'b0, 2'd0, '1);
      run("R10 shift zero");
      for (int op = 0; op < 4; op++) begin
         fill_random();
         set_ctl(2'd1, 4'd2, 4'hf, 4'hf, op[0], 1'b1, 2'(op), '1);
         run($sformatf("R11 fuse op%0d", op));
      end

      // R12: output must not change before the capturing edge
      for (int i = 0; i < LANES; i++) prev[i] = dst_vec[i*DW +: DW];
      @(negedge clk);
      fill_random();
      set_ctl(2'd0, 4'd0, 4'hf, 4'hf, 1'b0, 1'b0, 2'd0, '1);
      pack_inputs();
      #1;
      for (int i = 0; i < LANES; i++) exp_m[i] = prev[i];
      compare("R12 before edge");
      for (int i = 0; i < LANES; i++) exp_m[i] = model(i);
      @(negedge clk);
      compare("R12 after edge");

      for (int n = 0; n < 400; n++) begin
         fill_random();
         set_ctl(2'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
                 1'($urandom), 1'($urandom), 2'($urandom),
                 {$urandom, $urandom} | (($urandom % 2 == 0) ? '1 : '0));
         run("R2 R11 random");
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule